// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Engine

This block sits behind the two-wire protocol engine of a serial nonvolatile memory and owns the write side of the array. The protocol engine hands it a word address when one is loaded and then strobes each received data byte. The block stores those bytes in a buffer the size of one array page. Nothing reaches the array until the protocol engine reports a stop condition that ends a write transfer.

On that stop, the block checks the write-protect input against the target page. If the write is allowed, it drains the buffered bytes into a synchronous array write port, one byte per clock. It then holds a busy flag for a self-timed program interval whose length is a parameter counted in system clocks. While busy is high, every strobe from the protocol engine is ignored, so the bus side can answer acknowledge polling with silence. The block also keeps the current-address register that later reads start from.

The array holds 2^ADDR_W bytes split into pages of PAGE_BYTES bytes, where PAGE_BYTES is a power of two. The byte index is the low log2(PAGE_BYTES) address bits and the page number is the remaining upper bits. With the defaults, that is 4096 bytes in 128 pages of 32.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy and arr_we are low and cur_addr is zero.
- R2: A single byte loaded at address A and followed by a stop is written to array address A. busy and arr_we both rise in the cycle after the stop strobe.
- R3: Consecutive data bytes fill consecutive byte indices of the loaded page. The commit writes only the loaded indices, one per clock, in ascending index order, all within the same page.
- R4: The byte index wraps from PAGE_BYTES-1 to 0 without changing the page number. When more than PAGE_BYTES bytes arrive, the last byte sent to an index is the one committed.
- R5: arr_we stays low while bytes are being loaded, before the stop.
- R6: When wp is high at the stop and the page's two top address bits are 11, no array write happens, busy stays low and the buffered bytes are dropped. Other quarters are written whatever the level of wp. With wp low, the top quarter is written too.
- R7: busy stays high for exactly N + PROG_CYCLES clocks, where N is the number of distinct indices committed. While busy is high, address loads, byte strobes, starts and stops have no effect on cur_addr or on the buffer.
- R8: An address load sets cur_addr to the loaded address. Each accepted byte sets cur_addr to the address of that byte plus one, with the increment wrapped inside the page.
- R9: A stop with no bytes buffered starts no write and no busy interval. A start condition drops any buffered bytes, so a following stop writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: a new word address is present on addr_in |
| addr_in | input | ADDR_W | Word address from the protocol engine |
| byte_stb | input | 1 | Strobe: one received data byte is present on byte_in |
| byte_in | input | DATA_W | Received data byte |
| bus_start | input | 1 | Strobe: a start or repeated start was seen |
| stop_wr | input | 1 | Strobe: a stop ended a write transfer |
| wp | input | 1 | Write-protect level for the top address quarter |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit or program interval in progress |
| cur_addr | output | ADDR_W | Current-address register |

## Verification
The bench starts a page write two bytes before the end of a page. A design that carried the index into the page number would write the last two bytes into the next page, and cur_addr would land there too. An overlong transfer of PAGE_BYTES+1 bytes checks that the first index holds the last value, which a design that locked entries after their first write would get wrong. Strobes issued during busy are followed by an extra empty stop, so a buffer that silently accepted a byte while busy would show up as an extra array write. Protected and unprotected quarters are written with wp at both levels, and a design that decoded the wrong address bits would either write the blocked quarter or block a writable one.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COMMIT  = 2'd1,
    PH_PROGRAM = 2'd2
  } phase_t;

  // Guarded region: the two most significant address bits both set.
  function automatic logic in_guarded_quarter(input logic [1:0] msb2);
    return msb2 == 2'b11;
  endfunction

endpackage

// File: rtl/pwe_page_buffer.sv
module pwe_page_buffer #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              drop_en,
  input  logic [IDX_W-1:0]  sel_idx,
  output logic [DATA_W-1:0] sel_data,
  output logic [PAGE_BYTES-1:0] loaded
);

  logic [DATA_W-1:0] slot_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit_wr;
    logic hit_drop;
    assign hit_wr   = wr_en   && (wr_idx  == IDX_W'(g));
    assign hit_drop = drop_en && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (hit_wr) slot_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        loaded[g] <= 1'b0;
      else if (clear)    loaded[g] <= 1'b0;
      else if (hit_wr)   loaded[g] <= 1'b1;
      else if (hit_drop) loaded[g] <= 1'b0;
    end
  end

  assign sel_data = slot_q[sel_idx];

endmodule

// File: rtl/pwe_commit_pick.sv
module pwe_commit_pick #(
  parameter int PAGE_BYTES = 32,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic [PAGE_BYTES-1:0] mask,
  output logic                  any,
  output logic                  only_one,
  output logic [IDX_W-1:0]      idx
);

  // Lowest set bit wins: scan from the top down so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end

  assign any      = |mask;
  assign only_one = any && ((mask & (mask - 1'b1)) == '0);

endmodule

// File: rtl/pwe_prog_timer.sv
module pwe_prog_timer #(
  parameter int PROG_CYCLES = 1250000,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pwe_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              bus_start,
  input  logic              stop_wr,
  input  logic              wp,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i);
    return IDX_W'(i + 1'b1);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] p,
                                                  input logic [IDX_W-1:0]  i);
    return {p, i};
  endfunction

  phase_t             phase_q;
  logic [PAGE_W-1:0]  page_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ADDR_W-1:0]  cur_q;

  logic                  idle;
  logic                  in_commit;
  logic                  ev_addr;
  logic                  ev_byte;
  logic                  ev_start;
  logic                  ev_stop;
  logic                  ev_commit_go;
  logic                  ev_commit_drop;
  logic                  ev_last;
  logic                  prog_done;
  logic                  page_blocked;
  logic                  buf_clear;
  logic [PAGE_BYTES-1:0] loaded;
  logic                  pick_any;
  logic                  pick_one;
  logic [IDX_W-1:0]      pick_idx;
  logic [DATA_W-1:0]     pick_data;

  assign idle      = (phase_q == PH_IDLE);
  assign in_commit = (phase_q == PH_COMMIT);

  // Strobes only count while idle; address load outranks a byte in one cycle.
  assign ev_addr  = idle && addr_load;
  assign ev_byte  = idle && byte_stb && !addr_load;
  assign ev_start = idle && bus_start;
  assign ev_stop  = idle && stop_wr && !bus_start;

  assign page_blocked   = wp && in_guarded_quarter(page_q[PAGE_W-1 -: 2]);
  assign ev_commit_go   = ev_stop && pick_any && !page_blocked;
  assign ev_commit_drop = ev_stop && pick_any &&  page_blocked;
  assign ev_last        = in_commit && pick_one;
  assign buf_clear      = ev_addr || ev_start || ev_commit_drop;

  pwe_page_buffer #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (buf_clear),
    .wr_en    (ev_byte),
    .wr_idx   (idx_q),
    .wr_data  (byte_in),
    .drop_en  (arr_we),
    .sel_idx  (pick_idx),
    .sel_data (pick_data),
    .loaded   (loaded)
  );

  pwe_commit_pick #(
    .PAGE_BYTES (PAGE_BYTES)
  ) u_pick (
    .mask     (loaded),
    .any      (pick_any),
    .only_one (pick_one),
    .idx      (pick_idx)
  );

  pwe_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_last),
    .expire (prog_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:    if (ev_commit_go) phase_q <= PH_COMMIT;
        PH_COMMIT:  if (ev_last)      phase_q <= PH_PROGRAM;
        PH_PROGRAM: if (prog_done)    phase_q <= PH_IDLE;
        default:                      phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      idx_q  <= '0;
      cur_q  <= '0;
    end else if (ev_addr) begin
      page_q <= addr_in[ADDR_W-1:IDX_W];
      idx_q  <= addr_in[IDX_W-1:0];
      cur_q  <= addr_in;
    end else if (ev_byte) begin
      idx_q  <= idx_step(idx_q);
      cur_q  <= join_addr(page_q, idx_step(idx_q));
    end
  end

  assign arr_we    = in_commit && pick_any;
  assign arr_addr  = join_addr(page_q, pick_idx);
  assign arr_wdata = pick_data;
  assign busy      = !idle;
  assign cur_addr  = cur_q;

endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic              stop_wr,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              ev_commit_go
);

  logic wp_at_go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wp_at_go_q <= 1'b0;
    else if (ev_commit_go) wp_at_go_q <= wp;
  end

  assert_commit_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit_go |=> busy && arr_we);

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && $past(arr_we) |->
      (arr_addr[IDX_W-1:0] > $past(arr_addr[IDX_W-1:0])) &&
      (arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W])));

  assert_guarded_quarter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && (arr_addr[ADDR_W-1 -: 2] == 2'b11) |-> !wp_at_go_q);

  assert_write_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));

  assert_idle_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr && !busy && !ev_commit_go |=> !busy);

endmodule

bind page_write_engine pwe_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES)
) u_pwe_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp           (wp),
  .stop_wr      (stop_wr),
  .busy         (busy),
  .arr_we       (arr_we),
  .arr_addr     (arr_addr),
  .cur_addr     (cur_addr),
  .ev_commit_go (ev_commit_go)
);

// File: tb/tb_page_write_engine.sv
`timescale 1ns/1ps
module tb_page_write_engine;

  localparam int AW   = 12;
  localparam int DW   = 8;
  localparam int PB   = 32;
  localparam int PROG = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          byte_stb = 1'b0;
  logic [DW-1:0] byte_in = '0;
  logic          bus_start = 1'b0;
  logic          stop_wr = 1'b0;
  logic          wp = 1'b0;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic          busy;
  logic [AW-1:0] cur_addr;

  always #2 clk = ~clk;

  page_write_engine #(
    .ADDR_W(AW), .PAGE_BYTES(PB), .DATA_W(DW), .PROG_CYCLES(PROG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .bus_start(bus_start),
    .stop_wr(stop_wr), .wp(wp), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .busy(busy), .cur_addr(cur_addr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int            wr_cnt = 0;
  int            first_addr = -1;

  // Array model, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      mem[arr_addr] = arr_wdata;
      if (wr_cnt == 0) first_addr = int'(arr_addr);
      wr_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_addr(input int a);
    @(negedge clk); addr_load = 1'b1; addr_in = AW'(a);
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic pulse_byte(input int d);
    @(negedge clk); byte_stb = 1'b1; byte_in = DW'(d);
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_wr = 1'b1;
    @(negedge clk); stop_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0;
    first_addr = -1;
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 arr_we", int'(arr_we), 0);
    check("R1 cur_addr", int'(cur_addr), 0);
  endtask

  task automatic t_byte_write();
    int n;
    clear_log();
    pulse_addr(12'h123);
    check("R8 cur_addr after load", int'(cur_addr), 'h123);
    pulse_byte(8'hA5);
    check("R8 cur_addr after byte", int'(cur_addr), 'h124);
    check("R5 no write before stop", wr_cnt, 0);
    @(negedge clk);
    stop_wr = 1'b1;
    @(negedge clk);
    stop_wr = 1'b0;
    check("R2 busy next cycle", int'(busy), 1);
    check("R2 arr_we next cycle", int'(arr_we), 1);
    wait_idle(n);
    check("R7 busy length single byte", n, 1 + PROG);
    check("R2 array data", int'(mem[12'h123]), 'hA5);
    check("R2 write count", wr_cnt, 1);
  endtask

  task automatic t_page_wrap();
    int n;
    clear_log();
    pulse_addr(5*PB + 30);
    pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33); pulse_byte(8'h44);
    check("R4 cur_addr wraps in page", int'(cur_addr), 5*PB + 2);
    check("R5 nothing written while loading", wr_cnt, 0);
    pulse_stop();
    wait_idle(n);
    check("R7 busy length four bytes", n, 4 + PROG);
    check("R3 write count", wr_cnt, 4);
    check("R3 lowest index first", first_addr, 5*PB);
    check("R4 index 30", int'(mem[5*PB+30]), 'h11);
    check("R4 index 31", int'(mem[5*PB+31]), 'h22);
    check("R4 wrapped index 0", int'(mem[5*PB+0]), 'h33);
    check("R4 wrapped index 1", int'(mem[5*PB+1]), 'h44);
    check("R4 next page untouched", int'(mem[6*PB+0]), 0);
  endtask

  task automatic t_overlong();
    int n;
    clear_log();
    pulse_addr(10*PB);
    for (int i = 0; i <= PB; i++) pulse_byte(8'h40 + i);
    check("R8 cur_addr after overlong", int'(cur_addr), 10*PB + 1);
    pulse_stop();
    wait_idle(n);
    check("R3 full page write count", wr_cnt, PB);
    check("R7 busy length full page", n, PB + PROG);
    check("R4 overwritten index 0", int'(mem[10*PB]), 'h40 + PB);
    check("R4 index 1 kept", int'(mem[10*PB+1]), 'h41);
    check("R3 last index", int'(mem[10*PB+PB-1]), 'h40 + PB - 1);
  endtask

  task automatic t_protect();
    int n;
    clear_log();
    wp = 1'b1;
    pulse_addr(12'hC10);
    pulse_byte(8'h77);
    pulse_stop();
    check("R6 guarded quarter no busy", int'(busy), 0);
    repeat (PROG) @(negedge clk);
    check("R6 guarded quarter no write", wr_cnt, 0);
    check("R6 guarded data unchanged", int'(mem[12'hC10]), 0);
    pulse_stop();
    check("R6 dropped bytes not replayed", wr_cnt, 0);
    pulse_addr(12'h810);
    pulse_byte(8'h5A);
    pulse_stop();
    wait_idle(n);
    check("R6 lower quarter writable with wp", int'(mem[12'h810]), 'h5A);
    wp = 1'b0;
    pulse_addr(12'hFFF);
    pulse_byte(8'hC3);
    pulse_stop();
    wait_idle(n);
    check("R6 top quarter writable without wp", int'(mem[12'hFFF]), 'hC3);
    check("R8 cur_addr wraps at page end", int'(cur_addr), 12'hFE0);
  endtask

  task automatic t_empty_and_start();
    clear_log();
    pulse_addr(12'h200);
    pulse_stop();
    check("R9 empty stop no busy", int'(busy), 0);
    pulse_addr(12'h300);
    pulse_byte(8'h11);
    pulse_start();
    pulse_stop();
    check("R9 start drops buffer no busy", int'(busy), 0);
    repeat (4) @(negedge clk);
    check("R9 no writes", wr_cnt, 0);
    check("R9 data not written", int'(mem[12'h300]), 0);
  endtask

  task automatic t_ignored_while_busy();
    int n;
    clear_log();
    pulse_addr(12'h050);
    pulse_byte(8'h3C);
    pulse_stop();
    pulse_addr(12'h700);
    pulse_byte(8'h99);
    pulse_start();
    pulse_stop();
    check("R7 still busy during strobes", int'(busy), 1);
    wait_idle(n);
    check("R7 cur_addr untouched by busy strobes", int'(cur_addr), 12'h051);
    check("R7 single write", wr_cnt, 1);
    pulse_stop();
    check("R7 byte during busy not buffered", int'(busy), 0);
    repeat (4) @(negedge clk);
    check("R7 no extra write", wr_cnt, 1);
    check("R7 address 0x700 untouched", int'(mem[12'h700]), 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overlong();
    t_protect();
    t_empty_and_start();
    t_ignored_while_busy();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule